// File: doc/BRIEF.md
# Clock-Stop SPI Master with Programmable Divider

This block is the master side of a serial link that runs only while a word is in flight. A one-cycle start request is taken only when the block is idle. On an accepted start the block captures the transmit word, the word length and the divider setting. It then pulls an active-low select line down and runs a serial clock, derived from the system clock, for exactly one word. The transmit word is shifted out most significant bit first. At the same time a word of equal length is collected from the receive line.

Outside a transfer the serial clock rests high. The first bit is put on the data line part-way through a lead-in period, before any clock edge. Each later bit is launched on a rising edge, and the receive line is sampled on each falling edge. After the final rising edge the data driver is turned off. Select is held for one more high phase and then released. In that same cycle a one-cycle done pulse marks the received word as valid.

Top module: `spi_cs_master`

## Requirements
- R1: With an effective divider value d, one serial-clock period (falling edge to falling edge) lasts d+1 system cycles.
- R2: For odd d the low and high phases each last (d+1)/2 cycles. For even d the low phase lasts d/2 cycles and the high phase d/2+1 cycles.
- R3: A divider input of 0 is treated as 1, which gives a 2-cycle period.
- R4: `sclk_o` is high whenever `ss_n_o` is high. `ss_n_o` falls one cycle after an accepted start. The first falling edge of `sclk_o` comes d+1 cycles after `ss_n_o` falls.
- R5: The most significant bit of the word (bit n-1 of `tx_word_i`) appears on `mosi_o` one low-phase width after `ss_n_o` falls. Each following bit, in descending order, is launched on a rising edge of `sclk_o`.
- R6: `miso_i` is sampled at each falling edge of `sclk_o`. The first sample lands in bit n-1 of `rx_word_o`, the last in bit 0, and bits above n-1 read 0.
- R7: `mosi_oe_o` is high only while `ss_n_o` is low. It rises with the first data bit and falls on the final rising edge of `sclk_o`.
- R8: `ss_n_o` rises one high-phase width after the final rising edge, which is (n+1)(d+1) cycles after it fell. `done_o` is high for exactly that one cycle, and `rx_word_o` holds the received word from then on.
- R9: The word length n is `len_i` limited to the range 4..32. Values below 4 act as 4 and values above 32 act as 32.
- R10: A start request while a transfer is running has no effect. Changes to `tx_word_i`, `len_i` or `div_i` after the accepted start do not alter the transfer.
- R11: After reset `ss_n_o`=1, `sclk_o`=1, `mosi_oe_o`=0, `done_o`=0 and `rx_word_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle transfer request |
| tx_word_i | input | WORD_MAX | Word to send, right-aligned |
| len_i | input | clog2(WORD_MAX+1) | Requested word length |
| div_i | input | DIV_W | Divider value d |
| miso_i | input | 1 | Serial receive data |
| rx_word_o | output | WORD_MAX | Last received word, right-aligned |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| sclk_o | output | 1 | Serial clock, idles high |
| ss_n_o | output | 1 | Active-low select |
| mosi_o | output | 1 | Serial transmit data |
| mosi_oe_o | output | 1 | Output enable for the transmit data driver |

## Verification
The bench builds the block with its defaults: 32-bit words, a minimum length of 4 and an 8-bit divider. Most transfers use divider values 0 to 12, so both the odd and the even phase rules and the zero-divider substitution come up many times. One directed transfer uses the largest setting, 255, which exercises the full counter width. Lengths are drawn from 0 to 40, which drives both clamps as well as the 4-bit and 32-bit extremes.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } xfer_state_e;

  function automatic int unsigned clamp_u(int unsigned v, int unsigned lo, int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/spi_cs_divcfg.sv
module spi_cs_divcfg #(
  parameter  int unsigned DIV_W = 8,
  localparam int unsigned CNT_W = DIV_W + 1
) (
  input  logic [DIV_W-1:0] div_i,
  output logic [CNT_W-1:0] per_m1_o,
  output logic [CNT_W-1:0] low_m1_o
);

  logic [DIV_W-1:0] d_eff;
  logic [CNT_W-1:0] d_ext;
  logic [CNT_W-1:0] low_w;

  always_comb begin
    d_eff    = (div_i == '0) ? DIV_W'(1) : div_i;
    d_ext    = {1'b0, d_eff};
    low_w    = (d_ext + CNT_W'(d_eff[0])) >> 1;
    per_m1_o = d_ext;
    low_m1_o = low_w - CNT_W'(1);
  end

  // R2: low phase must end strictly before the period does
  always_comb begin
    a_r2_low_inside_period: assert (low_m1_o < per_m1_o);
  end

endmodule

// File: rtl/spi_cs_phase.sv
module spi_cs_phase #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] per_m1_i,
  input  logic [CNT_W-1:0] low_m1_i,
  output logic             low_end_o,
  output logic             per_end_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (run_i) begin
      cnt_d = (cnt_q == per_m1_i) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign low_end_o = run_i && (cnt_q == low_m1_i);
  assign per_end_o = run_i && (cnt_q == per_m1_i);

  // R1: the period counter never passes the latched period
  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= per_m1_i);

endmodule

// File: rtl/spi_cs_shift.sv
module spi_cs_shift #(
  parameter  int unsigned WORD_MAX = 32,
  localparam int unsigned LEN_W    = $clog2(WORD_MAX + 1),
  localparam int unsigned IDX_W    = $clog2(WORD_MAX)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [WORD_MAX-1:0] tx_word_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                sample_i,
  input  logic                miso_i,
  output logic                tx_bit_o,
  output logic                all_in_o,
  output logic [WORD_MAX-1:0] rx_word_o
);

  logic [WORD_MAX-1:0] tx_q, tx_d;
  logic [WORD_MAX-1:0] rx_q, rx_d;
  logic [LEN_W-1:0]    bcnt_q, bcnt_d;
  logic [LEN_W-1:0]    idx_full;
  logic [IDX_W-1:0]    idx;

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    bcnt_d = bcnt_q;
    if (load_i) begin
      tx_d   = tx_word_i;
      rx_d   = '0;
      bcnt_d = '0;
    end else if (sample_i) begin
      rx_d   = {rx_q[WORD_MAX-2:0], miso_i};
      bcnt_d = bcnt_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      bcnt_q <= '0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      bcnt_q <= bcnt_d;
    end
  end

  always_comb begin
    idx_full = len_i - LEN_W'(1) - bcnt_q;
    idx      = idx_full[IDX_W-1:0];
  end

  assign tx_bit_o  = tx_q[idx];
  assign all_in_o  = (bcnt_q == len_i);
  assign rx_word_o = rx_q;

  // R6: no sample beyond the word length
  a_r6_no_extra_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |-> bcnt_q < len_i);

endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
  import spi_cs_pkg::*;
#(
  parameter  int unsigned WORD_MAX = 32,
  parameter  int unsigned MIN_LEN  = 4,
  parameter  int unsigned DIV_W    = 8,
  localparam int unsigned LEN_W    = $clog2(WORD_MAX + 1),
  localparam int unsigned CNT_W    = DIV_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [WORD_MAX-1:0] tx_word_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic                miso_i,
  output logic [WORD_MAX-1:0] rx_word_o,
  output logic                done_o,
  output logic                sclk_o,
  output logic                ss_n_o,
  output logic                mosi_o,
  output logic                mosi_oe_o
);

  xfer_state_e st_q, st_d;
  logic ss_q, ss_d, sclk_q, sclk_d, oe_q, oe_d, mosi_q, mosi_d, done_q, done_d;
  logic [WORD_MAX-1:0] rx_q, rx_d;
  logic [CNT_W-1:0]    per_q, low_q, per_w, low_w;
  logic [LEN_W-1:0]    len_q, len_fit;
  logic load, sample, busy, low_end, per_end, tx_bit, all_in;
  logic [WORD_MAX-1:0] rx_shift;

  assign busy = (st_q != ST_IDLE);

  always_comb begin
    len_fit = LEN_W'(clamp_u(32'(len_i), MIN_LEN, WORD_MAX));
  end

  spi_cs_divcfg #(.DIV_W(DIV_W)) u_divcfg (
    .div_i    (div_i),
    .per_m1_o (per_w),
    .low_m1_o (low_w)
  );

  spi_cs_phase #(.CNT_W(CNT_W)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (load),
    .run_i     (busy),
    .per_m1_i  (per_q),
    .low_m1_i  (low_q),
    .low_end_o (low_end),
    .per_end_o (per_end)
  );

  spi_cs_shift #(.WORD_MAX(WORD_MAX)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .tx_word_i (tx_word_i),
    .len_i     (len_q),
    .sample_i  (sample),
    .miso_i    (miso_i),
    .tx_bit_o  (tx_bit),
    .all_in_o  (all_in),
    .rx_word_o (rx_shift)
  );

  always_comb begin
    st_d   = st_q;
    ss_d   = ss_q;
    sclk_d = sclk_q;
    oe_d   = oe_q;
    mosi_d = mosi_q;
    done_d = 1'b0;
    rx_d   = rx_q;
    load   = 1'b0;
    sample = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d = ST_LEAD;
          ss_d = 1'b0;
          load = 1'b1;
        end
      end
      ST_LEAD: begin
        if (low_end) begin
          oe_d   = 1'b1;
          mosi_d = tx_bit;
        end else if (per_end) begin
          sclk_d = 1'b0;
          sample = 1'b1;
          st_d   = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (low_end) begin
          sclk_d = 1'b1;
          if (all_in) begin
            oe_d   = 1'b0;
            mosi_d = 1'b0;
            st_d   = ST_TRAIL;
          end else begin
            mosi_d = tx_bit;
          end
        end else if (per_end) begin
          sclk_d = 1'b0;
          sample = 1'b1;
        end
      end
      ST_TRAIL: begin
        if (per_end) begin
          ss_d   = 1'b1;
          done_d = 1'b1;
          rx_d   = rx_shift;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ss_q   <= 1'b1;
      sclk_q <= 1'b1;
      oe_q   <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      st_q   <= st_d;
      ss_q   <= ss_d;
      sclk_q <= sclk_d;
      oe_q   <= oe_d;
      mosi_q <= mosi_d;
      done_q <= done_d;
      rx_q   <= rx_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
      low_q <= '0;
      len_q <= LEN_W'(MIN_LEN);
    end else if (load) begin
      per_q <= per_w;
      low_q <= low_w;
      len_q <= len_fit;
    end
  end

  assign rx_word_o = rx_q;
  assign done_o    = done_q;
  assign sclk_o    = sclk_q;
  assign ss_n_o    = ss_q;
  assign mosi_o    = mosi_q;
  assign mosi_oe_o = oe_q;

  // R4: clock rests high while deselected
  a_r4_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_n_o |-> sclk_o);

  // R4: a falling clock edge only occurs with select already low
  a_r4_select_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> (!ss_n_o && $past(!ss_n_o)));

  // R7: driver enabled only inside select
  a_r7_oe_inside_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mosi_oe_o |-> !ss_n_o);

  // R7: driver switched off together with a rising clock edge
  a_r7_oe_off_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mosi_oe_o) |-> $rose(sclk_o));

  // R8: done is a single pulse marking the release of select
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_at_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(ss_n_o));

  // R10: a start while busy leaves the latched configuration alone
  a_r10_busy_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i) |=> ($stable(len_q) && $stable(per_q) && $stable(low_q)));

endmodule

// File: tb/spi_cs_master_tb.sv
module spi_cs_master_tb_top;

  localparam int WMAX = 32;
  localparam int DW   = 8;
  localparam int LW   = 6;

  logic            clk;
  logic            rst_n;
  logic            start;
  logic [WMAX-1:0] tx_word;
  logic [LW-1:0]   len;
  logic [DW-1:0]   div;
  logic            miso;
  logic [WMAX-1:0] rx_word;
  logic            done, sclk, ss_n, mosi, mosi_oe;

  int checks = 0;
  int fails  = 0;

  spi_cs_master dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .tx_word_i (tx_word),
    .len_i     (len),
    .div_i     (div),
    .miso_i    (miso),
    .rx_word_o (rx_word),
    .done_o    (done),
    .sclk_o    (sclk),
    .ss_n_o    (ss_n),
    .mosi_o    (mosi),
    .mosi_oe_o (mosi_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int fit_len(int raw);
    if (raw < 4) return 4;
    if (raw > 32) return 32;
    return raw;
  endfunction

  function automatic int fit_div(int raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  task automatic run_xfer(input logic [31:0] tx, input logic [31:0] rxp,
                          input int dv, input int lraw, input int busy_at,
                          input string tag);
    int n, d, p, l, total;
    int e_ss, e_ck, e_oe, e_mo, e_dn;
    longint a_ss, x_ss, a_ck, x_ck, a_oe, x_oe, a_mo, x_mo, a_dn, x_dn;
    logic [31:0] rx_exp;
    n = fit_len(lraw);
    d = fit_div(dv);
    p = d + 1;
    l = (d + (d % 2)) / 2;
    total = (n + 1) * p;
    rx_exp = (n == 32) ? rxp : (rxp & ((32'd1 << n) - 1));
    e_ss = 0; e_ck = 0; e_oe = 0; e_mo = 0; e_dn = 0;
    a_ss = 0; x_ss = 0; a_ck = 0; x_ck = 0; a_oe = 0; x_oe = 0;
    a_mo = 0; x_mo = 0; a_dn = 0; x_dn = 0;
    @(negedge clk);
    start   = 1'b1;
    tx_word = tx;
    len     = LW'(lraw);
    div     = DW'(dv);
    miso    = rxp[n-1];
    @(negedge clk);
    start   = 1'b0;
    tx_word = $urandom;
    len     = LW'($urandom_range(0, 63));
    div     = DW'($urandom_range(0, 255));
    for (int c = 0; c <= total + 2; c++) begin
      logic es, ec, eo, em, ed;
      int j, bi;
      es = !(c < total);
      if (c < p) ec = 1'b1;
      else if (c < total) ec = (((c - p) % p) >= l);
      else ec = 1'b1;
      eo = (c >= l) && (c < n * p + l);
      ed = (c == total);
      if (ss_n !== es && e_ss == 0) begin a_ss = ss_n; x_ss = es; end
      if (ss_n !== es) e_ss++;
      if (sclk !== ec && e_ck == 0) begin a_ck = sclk; x_ck = ec; end
      if (sclk !== ec) e_ck++;
      if (mosi_oe !== eo && e_oe == 0) begin a_oe = mosi_oe; x_oe = eo; end
      if (mosi_oe !== eo) e_oe++;
      if (done !== ed && e_dn == 0) begin a_dn = done; x_dn = ed; end
      if (done !== ed) e_dn++;
      if (eo) begin
        bi = (c < p + l) ? n - 1 : n - 1 - ((c - p - l) / p + 1);
        em = tx[bi];
        if (mosi !== em && e_mo == 0) begin a_mo = mosi; x_mo = em; end
        if (mosi !== em) e_mo++;
      end
      if (c == total)
        chk(rx_word === rx_exp, {tag, " R6 R8"}, "rx_word at done", rx_word, rx_exp);
      start = (c == busy_at);
      j = c / p;
      miso = (j < n) ? rxp[n-1-j] : 1'($urandom);
      @(negedge clk);
    end
    start = 1'b0;
    chk(e_ss == 0, {tag, " R4 R8"}, "ss_n timeline", a_ss, x_ss);
    chk(e_ck == 0, {tag, " R1 R2"}, "sclk timeline", a_ck, x_ck);
    chk(e_oe == 0, {tag, " R7"}, "mosi_oe timeline", a_oe, x_oe);
    chk(e_mo == 0, {tag, " R5"}, "mosi bit order", a_mo, x_mo);
    chk(e_dn == 0, {tag, " R8"}, "done pulse", a_dn, x_dn);
    chk(rx_word === rx_exp, {tag, " R6"}, "rx_word held", rx_word, rx_exp);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; start = 1'b0; tx_word = '0; len = '0; div = '0; miso = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(ss_n === 1'b1, "R11", "ss_n after reset", ss_n, 1);
    chk(sclk === 1'b1, "R11", "sclk after reset", sclk, 1);
    chk(mosi_oe === 1'b0 && done === 1'b0, "R11", "oe/done after reset",
        {mosi_oe, done}, 0);
    chk(rx_word === '0, "R11", "rx_word after reset", rx_word, 0);

    // directed corners
    run_xfer(32'hA5C3_0F1E, 32'h3C5A_9966, 0, 8, -1, "R3 div0");
    run_xfer(32'h0000_0009, 32'h0000_0006, 1, 4, -1, "R2 div1");
    run_xfer(32'h1234_5678, 32'h8765_4321, 2, 16, 10, "R10 div2");
    run_xfer(32'hFFFF_0000, 32'h0F0F_F0F0, 3, 0, -1, "R9 len0");
    run_xfer(32'hDEAD_BEEF, 32'hCAFE_F00D, 4, 63, 40, "R9 R10 len63");
    run_xfer(32'h8000_0001, 32'h7FFF_FFFE, 5, 32, -1, "R9 len32");
    run_xfer(32'h0000_0015, 32'h0000_000A, 255, 5, 700, "R2 div255");

    // constrained random
    for (int k = 0; k < 30; k++) begin
      logic [31:0] t, r;
      int dv, ln, ba;
      t  = $urandom;
      r  = $urandom;
      dv = $urandom_range(0, 12);
      ln = $urandom_range(0, 40);
      ba = ($urandom_range(0, 1) == 1) ? $urandom_range(0, (fit_len(ln) + 1) * (fit_div(dv) + 1) - 1) : -1;
      run_xfer(t, r, dv, ln, ba, "R1 R2 R5 R6 rand");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule